// File: doc/BRIEF.md
# Glitch-Free Programmable Card Clock Generator

This block derives the clock for an inserted smart card from the system clock. A programmable half-period, counted in system clocks, sets both the high and the low width of the card clock. The card uses this clock for its serial bit timing. If the card contains a processor, the same clock also runs that processor. Because of this, every high and low phase must keep its full programmed width, including the phases around a change of rate.

Software writes a new half-period at any time by presenting it with a one-cycle load strobe. The value is parked in a shadow register, and a pending flag rises. The value moves into the active divider only at the next phase boundary, and the flag drops in that same cycle. A phase that is already under way therefore finishes at the old width, and the next phase runs at the new width. When the enable is withdrawn, the clock finishes its current pulse, including the following low phase, and then rests low.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, card_clk and upd_pend are low. After reset, the active half-period is RST_DIV (default 4) system clocks.
- R2: While enabled, every high phase and every low phase of card_clk lasts exactly N system clocks, where N is the active half-period value. A value of 0 gives N = 1.
- R3: upd_pend rises in the cycle after div_load is sampled high. It stays high until the shadow value becomes active, and it falls in the cycle in which that value first governs a phase.
- R4: A value loaded during a phase does not change that phase. That phase completes at the old width, and the phases after the commit use the new width. No phase is shorter than the smaller of the two settings.
- R5: A second load before the commit replaces the shadow value. Only the last loaded value takes effect.
- R6: When en falls during a high phase, that high phase completes at full width. card_clk then stays low, with no further rising edge while en is low.
- R7: While the clock is stopped, a loaded value is committed on the next clock edge. upd_pend is then high for exactly one cycle, and the next started clock uses the new value.
- R8: While en is low after reset, card_clk stays low. When en is sampled high while the clock is stopped, card_clk goes high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request for the card clock |
| div_val | input | DIV_W | New half-period in system clocks (0 acts as 1) |
| div_load | input | 1 | One-cycle strobe that captures div_val into the shadow register |
| card_clk | output | 1 | Generated card clock |
| upd_pend | output | 1 | High while a loaded value waits for a phase boundary |

## Verification
The hardest case to reach from the ports is a load that lands inside a long phase, especially when a second load follows before the boundary. The same applies to withdrawing the enable partway through a high phase. The stimulus first programs a wide half-period, then follows the observed card clock until a phase has just started. It issues the loads or drops the enable a few cycles later, so the request falls clearly inside the phase. It then measures every completed phase width around the commit.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    localparam int unsigned CCG_DIV_W   = 16;
    localparam int unsigned CCG_RST_DIV = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } ccg_phase_e;

    typedef struct packed {
        logic boundary;
        logic commit;
    } ccg_tick_t;

    // Phase order: a high phase is always followed by a full low phase.
    function automatic ccg_phase_e ccg_next_phase(input ccg_phase_e cur, input logic run);
        ccg_phase_e nxt;
        unique case (cur)
            PH_IDLE: nxt = run ? PH_HIGH : PH_IDLE;
            PH_HIGH: nxt = PH_LOW;
            PH_LOW:  nxt = run ? PH_HIGH : PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic ccg_level(input ccg_phase_e cur);
        return cur == PH_HIGH;
    endfunction

endpackage

// File: rtl/ccg_shadow.sv
module ccg_shadow #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic [W-1:0] shadow,
    output logic         pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            pend   <= 1'b0;
        end else if (ld) begin
            shadow <= din;
            pend   <= 1'b1;
        end else if (take) begin
            pend   <= 1'b0;
        end
    end

    // R5
    shadow_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> (shadow == $past(din)) && pend);

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |=> pend);

endmodule

// File: rtl/ccg_phase_gen.sv
module ccg_phase_gen
    import ccg_pkg::*;
#(
    parameter int unsigned W       = 16,
    parameter int unsigned RST_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pend,
    input  logic [W-1:0] shadow,
    output ccg_tick_t    tick,
    output logic         card_clk
);

    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] RST_VAL = W'(RST_DIV);

    ccg_phase_e   ph;
    logic [W-1:0] cnt;
    logic [W-1:0] active;
    logic [W-1:0] lim;
    logic         boundary;

    assign lim      = (active == '0) ? ONE : active;
    assign boundary = (ph == PH_IDLE) || (cnt == lim - ONE);

    always_comb begin
        tick.boundary = boundary;
        tick.commit   = boundary && pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            active <= RST_VAL;
        end else if (boundary) begin
            ph  <= ccg_next_phase(ph, en);
            cnt <= '0;
            if (pend) begin
                active <= shadow;
            end
        end else begin
            cnt <= cnt + ONE;
        end
    end

    assign card_clk = ccg_level(ph);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE) |-> (cnt < lim));

    // R4
    active_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> $past(boundary));

    // R6
    high_to_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HIGH) |=> (ph != PH_IDLE));

    // R8
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && en) |=> (ph == PH_HIGH));

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import ccg_pkg::*;
#(
    parameter int unsigned DIV_W   = CCG_DIV_W,
    parameter int unsigned RST_DIV = CCG_RST_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             div_load,
    output logic             card_clk,
    output logic             upd_pend
);

    ccg_tick_t        tick;
    logic [DIV_W-1:0] shadow;
    logic             rst_d;

    ccg_shadow #(.W(DIV_W)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .ld     (div_load),
        .din    (div_val),
        .take   (tick.commit),
        .shadow (shadow),
        .pend   (upd_pend)
    );

    ccg_phase_gen #(.W(DIV_W), .RST_DIV(RST_DIV)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .pend     (upd_pend),
        .shadow   (shadow),
        .tick     (tick),
        .card_clk (card_clk)
    );

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_d) begin
            reset_idle_chk: assert (card_clk == 1'b0 && upd_pend == 1'b0);
        end
    end

    // R3
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pend) |-> $past(tick.commit));

    // R2
    edge_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(card_clk) || $fell(card_clk)) |-> $past(tick.boundary));

endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;

    localparam int W = 16;
    localparam logic [W-1:0] TBL [8] = '{16'd1, 16'd2, 16'd3, 16'd5,
                                         16'd0, 16'd7, 16'd16, 16'd4};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         div_load = 1'b0;
    logic [W-1:0] div_val = '0;
    logic         card_clk;
    logic         upd_pend;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    card_clk_gen uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .div_val  (div_val),
        .div_load (div_load),
        .card_clk (card_clk),
        .upd_pend (upd_pend)
    );

    // Phase-width monitor, sampled on the falling edge.
    logic prev_lvl = 1'b0;
    int run_len = 0;
    int last_high = 0;
    int last_low = 0;
    int min_run = 1 << 30;
    int max_run = 0;
    int changes = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_lvl = 1'b0;
            run_len  = 0;
        end else if (card_clk === prev_lvl) begin
            run_len++;
        end else begin
            if (prev_lvl) last_high = run_len;
            else          last_low  = run_len;
            if (run_len < min_run) min_run = run_len;
            if (run_len > max_run) max_run = run_len;
            changes++;
            prev_lvl = card_clk;
            run_len  = 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] v);
        div_val  = v;
        div_load = 1'b1;
        step();
        div_load = 1'b0;
    endtask

    task automatic wait_change();
        int c0;
        c0 = changes;
        while (changes == c0) step();
    endtask

    task automatic clear_stats();
        min_run = 1 << 30;
        max_run = 0;
    endtask

    task automatic wait_commit();
        while (upd_pend) step();
    endtask

    function automatic int half_of(input logic [W-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    initial begin
        int c_fall;
        // R1: reset state
        repeat (4) step();
        check("R1 card_clk in reset", int'(card_clk), 0);
        check("R1 upd_pend in reset", int'(upd_pend), 0);
        rst = 1'b0;

        // R8: stays low while disabled, rises one cycle after enable
        repeat (10) step();
        check("R8 low while disabled", int'(card_clk), 0);
        en = 1'b1;
        step();
        check("R8 rise after enable", int'(card_clk), 1);
        wait_change();
        wait_change();
        check("R1 reset half-period high", last_high, 4);
        wait_change();
        check("R1 reset half-period low", last_low, 4);

        // R2: table of half-period values
        for (int i = 0; i < 8; i++) begin
            load(TBL[i]);
            wait_commit();
            wait_change();
            clear_stats();
            wait_change();
            wait_change();
            check("R2 min phase width", min_run, half_of(TBL[i]));
            check("R2 max phase width", max_run, half_of(TBL[i]));
        end

        // R4: load inside a long phase
        load(16'd12);
        wait_commit();
        wait_change();
        wait_change();
        clear_stats();
        step();
        step();
        load(16'd3);
        check("R3 pending after load", int'(upd_pend), 1);
        wait_change();
        check("R4 phase in progress keeps old width", max_run, 12);
        check("R3 pending cleared at boundary", int'(upd_pend), 0);
        wait_change();
        wait_change();
        check("R4 new width after commit", min_run, 3);
        check("R4 no phase beyond old width", max_run, 12);

        // R5: last write wins
        load(16'd20);
        wait_commit();
        wait_change();
        wait_change();
        load(16'd3);
        check("R3 pending after first load", int'(upd_pend), 1);
        load(16'd6);
        repeat (5) step();
        check("R3 pending held until boundary", int'(upd_pend), 1);
        wait_commit();
        wait_change();
        clear_stats();
        wait_change();
        wait_change();
        check("R5 last value min width", min_run, 6);
        check("R5 last value max width", max_run, 6);

        // R6: disable during a high phase
        while (card_clk !== 1'b1) step();
        step();
        en = 1'b0;
        wait_change();
        check("R6 high completes at full width", last_high, 6);
        c_fall = changes;
        repeat (40) step();
        check("R6 rests low", int'(card_clk), 0);
        check("R6 no further edges", changes - c_fall, 0);

        // R7: commit while stopped
        load(16'd9);
        check("R7 pending one cycle", int'(upd_pend), 1);
        step();
        check("R7 pending cleared while idle", int'(upd_pend), 0);
        en = 1'b1;
        step();
        check("R8 rise after re-enable", int'(card_clk), 1);
        wait_change();
        check("R6 low plus rest not short", int'(last_low >= 6), 1);
        wait_change();
        check("R7 idle-loaded width used", last_high, 9);

        // R1: reset during operation
        while (card_clk !== 1'b1) step();
        load(16'd15);
        rst = 1'b1;
        step();
        check("R1 mid-run reset clock low", int'(card_clk), 0);
        check("R1 mid-run reset pending low", int'(upd_pend), 0);
        step();
        rst = 1'b0;
        step();
        check("R8 rise after reset release", int'(card_clk), 1);
        wait_change();
        wait_change();
        check("R1 divider back to reset value", last_high, 4);

        finish_run();
    end

endmodule